// File: doc/BRIEF.md
# Reset Release Delay Sequencer

This block decides when the system reset may be released and when the oscillator clock may be handed to the core after a reset or a wake-up. When a reset request arrives, the block steps through a chain of timed phases in a fixed order. The chain it builds depends on two things: the reset cause, and the class of the selected clock source. A power-on reset adds a power-on delay and a start-up delay. The start-up delay is short when the on-chip regulator is enabled and much longer when it is disabled. Crystal sources add a count of oscillator rising edges. PLL sources add a lock wait. Any reset that runs on a crystal or PLL source ends with a clock-monitor delay, and at the end of that delay a start pulse is issued to the clock monitor.

A wake from a powered-down state uses the same engine without touching the system reset. It runs the short start-up delay only when the regulator is enabled, then the oscillator count and the lock wait where the source needs them. All delays are parameters counted in ticks of the reference clock `clk`. The oscillator clock is brought into the reference domain by a synchronizer, and its rising edges are counted there. The current phase is exposed as a one-hot vector.

Top module: `reset_release_seq`

## Requirements
- R1: While `arst_n` is low, `phase` is 7'b0000001, `sys_rst`=1, `clk_rel`=0 and `mon_start`=0. After release, the block runs a power-on sequence with the live `clk_src` and `reg_en`.
- R2: A reset with cause code 0 (power-on) starts in the POR phase and stays there exactly T_POR cycles. It then goes to the STARTUP phase.
- R3: In a reset sequence, STARTUP lasts T_SU_REG cycles when `reg_en`=1 and T_PWRT cycles when `reg_en`=0.
- R4: Every reset passes through the RST phase for exactly T_RST cycles. Cause codes 1 to 7 (pin, watchdog, software, illegal opcode, uninitialized register, trap conflict, spare) enter RST directly and skip POR, STARTUP, OST and LOCK.
- R5: For source classes 2 and 3 (crystal, crystal+PLL), a power-on or wake sequence has an OST phase. OST ends on the OST_COUNT-th synchronized rising edge of `osc_clk` seen inside the phase.
- R6: For source classes 1 and 3 (PLL), a power-on or wake sequence has a LOCK phase. LOCK lasts at least T_LOCK cycles and does not end while `pll_locked` is low.
- R7: For classes 1, 2 and 3, a reset ends with an FSCM phase of T_FSCM cycles. `mon_start` then pulses for one cycle, in the first RUN cycle. Classes 0 and 4 to 7 (external/RC, low-power RC) have no FSCM phase and no pulse.
- R8: During a reset sequence, `sys_rst` is 1 in POR, STARTUP, OST, LOCK and RST, and 0 in FSCM and RUN. `clk_rel` is 1 exactly in RST, FSCM and RUN.
- R9: `wake_req` in RUN starts a wake sequence: STARTUP (T_SU_REG) only when `reg_en`=1, then OST for classes 2 and 3, then LOCK for classes 1 and 3, then RUN. There is no RST or FSCM phase, and `sys_rst` stays 0 throughout.
- R10: `wake_req` outside the RUN phase is ignored. The running sequence continues unchanged.
- R11: `rst_req` at any time, including mid-sequence, restarts from the first applicable phase for the new `rst_cause`. `rst_req` takes priority over a simultaneous `wake_req`.
- R12: Phases occur only in the order POR, STARTUP, OST, LOCK, RST, FSCM, RUN, skipping those that do not apply. `phase` bit 0 is POR, 1 is STARTUP, 2 is OST, 3 is LOCK, 4 is RST, 5 is FSCM and 6 is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all delays count its ticks |
| arst_n | input | 1 | Asynchronous active-low block reset (power-on) |
| rst_req | input | 1 | One-cycle reset request |
| rst_cause | input | 3 | Reset cause, 0 = power-on, 1..7 other causes; valid with `rst_req` |
| wake_req | input | 1 | One-cycle request to return from a powered-down state |
| clk_src | input | 3 | Source class: 0 ext/RC, 1 ext/RC+PLL, 2 crystal, 3 crystal+PLL, 4 low-power RC |
| reg_en | input | 1 | On-chip regulator enabled |
| osc_clk | input | 1 | Oscillator clock, asynchronous to `clk` |
| pll_locked | input | 1 | PLL lock indication, in the `clk` domain |
| sys_rst | output | 1 | System reset, active high |
| clk_rel | output | 1 | Oscillator clock released to the core |
| mon_start | output | 1 | One-cycle start pulse for the clock monitor |
| phase | output | 7 | One-hot current phase |

## Verification
Some properties are checked on every cycle. These include: the exact dwell of the POR and RST phases whenever they end without a new request; the hold of LOCK while the PLL is unlocked; that a monitor pulse follows only an FSCM phase; that a non-power-on request lands in RST; that a wake outside RUN leaves the sequence untouched; and that RUN always shows reset released with the clock handed over. The bench scenarios are needed for everything that depends on a whole sequence. That covers which phases make up the chain for each cause and source class, the STARTUP length chosen by the regulator flag, the OST length measured against real oscillator edges, the wake chains, and restarts in the middle of a sequence.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int NPH = 7;

    typedef enum logic [2:0] {
        PH_POR  = 3'd0,
        PH_SU   = 3'd1,
        PH_OST  = 3'd2,
        PH_LOCK = 3'd3,
        PH_RST  = 3'd4,
        PH_FSCM = 3'd5,
        PH_RUN  = 3'd6
    } phase_e;

    localparam logic [2:0] CAUSE_POWERON = 3'd0;

    function automatic logic src_is_xtal(input logic [2:0] src);
        return (src == 3'd2) || (src == 3'd3);
    endfunction

    function automatic logic src_is_pll(input logic [2:0] src);
        return (src == 3'd1) || (src == 3'd3);
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rrs_osc_edge.sv
module rrs_osc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic osc_clk,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], osc_clk};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/rrs_phase_map.sv
module rrs_phase_map
    import rrs_pkg::*;
(
    input  logic   por,
    input  logic   wake,
    input  logic   xtal,
    input  logic   pll,
    input  logic   reg_en,
    input  phase_e cur,
    output phase_e first_ph,
    output phase_e next_ph
);
    logic [NPH-1:0] use_v;

    always_comb begin
        use_v[PH_POR]  = por && !wake;
        use_v[PH_SU]   = (por && !wake) || (wake && reg_en);
        use_v[PH_OST]  = (por || wake) && xtal;
        use_v[PH_LOCK] = (por || wake) && pll;
        use_v[PH_RST]  = !wake;
        use_v[PH_FSCM] = !wake && (xtal || pll);
        use_v[PH_RUN]  = 1'b1;
    end

    always_comb begin
        first_ph = PH_RUN;
        next_ph  = PH_RUN;
        for (int i = NPH - 2; i >= 0; i--) begin
            if (use_v[i]) first_ph = phase_e'(3'(i));
            if (use_v[i] && (i > int'(cur))) next_ph = phase_e'(3'(i));
        end
    end

endmodule

// File: rtl/rrs_len_sel.sv
module rrs_len_sel
    import rrs_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned T_POR     = 4,
    parameter int unsigned T_SU_REG  = 4,
    parameter int unsigned T_PWRT    = 4,
    parameter int unsigned T_RST     = 4,
    parameter int unsigned T_LOCK    = 4,
    parameter int unsigned T_FSCM    = 4,
    parameter int unsigned OST_COUNT = 4
) (
    input  phase_e          ph,
    input  logic            reg_en,
    output logic [CW-1:0]   len
);
    always_comb begin
        unique case (ph)
            PH_POR:  len = CW'(T_POR);
            PH_SU:   len = reg_en ? CW'(T_SU_REG) : CW'(T_PWRT);
            PH_OST:  len = CW'(OST_COUNT);
            PH_LOCK: len = CW'(T_LOCK);
            PH_RST:  len = CW'(T_RST);
            PH_FSCM: len = CW'(T_FSCM);
            default: len = CW'(1);
        endcase
    end

endmodule

// File: rtl/reset_release_seq.sv
module reset_release_seq
    import rrs_pkg::*;
#(
    parameter int unsigned T_POR     = 1000,
    parameter int unsigned T_SU_REG  = 2000,
    parameter int unsigned T_PWRT    = 6400000,
    parameter int unsigned T_RST     = 2000,
    parameter int unsigned T_LOCK    = 2000,
    parameter int unsigned T_FSCM    = 10000,
    parameter int unsigned OST_COUNT = 1024,
    parameter int          SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           arst_n,
    input  logic           rst_req,
    input  logic [2:0]     rst_cause,
    input  logic           wake_req,
    input  logic [2:0]     clk_src,
    input  logic           reg_en,
    input  logic           osc_clk,
    input  logic           pll_locked,
    output logic           sys_rst,
    output logic           clk_rel,
    output logic           mon_start,
    output logic [NPH-1:0] phase
);
    localparam int unsigned MAXT = umax(umax(umax(T_POR, T_SU_REG), umax(T_PWRT, T_RST)),
                                        umax(umax(T_LOCK, T_FSCM), OST_COUNT));
    localparam int unsigned CW = $clog2(MAXT + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          por;
        logic          wake;
        logic          srst;
        logic          crel;
        logic          mon;
    } st_t;

    st_t st_d, st_q;

    logic          osc_rise;
    logic          xtal, pll;
    logic          wake_ok;
    logic          por_n, wake_n;
    phase_e        first_ph, next_ph;
    logic [CW-1:0] len;
    logic          adv, at_end, done;

    assign xtal    = src_is_xtal(clk_src);
    assign pll     = src_is_pll(clk_src);
    assign wake_ok = wake_req && !rst_req && (st_q.ph == PH_RUN);
    assign por_n   = rst_req ? (rst_cause == CAUSE_POWERON) : (wake_ok ? 1'b0 : st_q.por);
    assign wake_n  = rst_req ? 1'b0 : (wake_ok ? 1'b1 : st_q.wake);

    rrs_osc_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .arst_n  (arst_n),
        .osc_clk (osc_clk),
        .rise    (osc_rise)
    );

    rrs_phase_map u_map (
        .por      (por_n),
        .wake     (wake_n),
        .xtal     (xtal),
        .pll      (pll),
        .reg_en   (reg_en),
        .cur      (st_q.ph),
        .first_ph (first_ph),
        .next_ph  (next_ph)
    );

    rrs_len_sel #(
        .CW(CW), .T_POR(T_POR), .T_SU_REG(T_SU_REG), .T_PWRT(T_PWRT),
        .T_RST(T_RST), .T_LOCK(T_LOCK), .T_FSCM(T_FSCM), .OST_COUNT(OST_COUNT)
    ) u_len (
        .ph     (st_q.ph),
        .reg_en (reg_en),
        .len    (len)
    );

    // Phase completion: OST advances on oscillator edges, LOCK also needs lock.
    assign adv    = (st_q.ph == PH_OST) ? osc_rise : 1'b1;
    assign at_end = (st_q.cnt == (len - CW'(1)));
    assign done   = adv && at_end && ((st_q.ph != PH_LOCK) || pll_locked);

    always_comb begin
        st_d     = st_q;
        st_d.mon = 1'b0;
        if (rst_req) begin
            st_d.por  = (rst_cause == CAUSE_POWERON);
            st_d.wake = 1'b0;
            st_d.ph   = first_ph;
            st_d.cnt  = '0;
        end else if (wake_ok) begin
            st_d.por  = 1'b0;
            st_d.wake = 1'b1;
            st_d.ph   = first_ph;
            st_d.cnt  = '0;
        end else if (st_q.ph != PH_RUN) begin
            if (done) begin
                st_d.ph  = next_ph;
                st_d.cnt = '0;
                st_d.mon = (st_q.ph == PH_FSCM);
            end else if (adv && !at_end) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
        st_d.srst = !st_d.wake && (st_d.ph inside {PH_POR, PH_SU, PH_OST, PH_LOCK, PH_RST});
        st_d.crel = st_d.ph inside {PH_RST, PH_FSCM, PH_RUN};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '{ph: PH_POR, cnt: '0, por: 1'b1, wake: 1'b0,
                      srst: 1'b1, crel: 1'b0, mon: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst   = st_q.srst;
    assign clk_rel   = st_q.crel;
    assign mon_start = st_q.mon;
    assign phase     = NPH'(1) << st_q.ph;

    // Independent dwell counter used only by the checks below.
    logic [CW-1:0] dwell_q;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                              dwell_q <= '0;
        else if (rst_req || (st_d.ph != st_q.ph)) dwell_q <= '0;
        else if (dwell_q != '1)                   dwell_q <= dwell_q + CW'(1);
    end

    assert_por_len_R2: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.ph == PH_POR && st_d.ph != PH_POR && !rst_req) |-> (dwell_q == CW'(T_POR - 1)));

    assert_rst_len_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.ph == PH_RST && st_d.ph != PH_RST && !rst_req) |-> (dwell_q == CW'(T_RST - 1)));

    assert_nonpor_to_rst_R4: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_req && rst_cause != CAUSE_POWERON) |=> (phase == NPH'(1 << 4)));

    assert_lock_wait_R6: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.ph == PH_LOCK && !pll_locked && !rst_req) |=> (st_q.ph == PH_LOCK));

    assert_mon_pulse_R7: assert property (@(posedge clk) disable iff (!arst_n)
        mon_start |-> ($past(st_q.ph) == PH_FSCM && st_q.ph == PH_RUN));

    assert_run_out_R8: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.ph == PH_RUN) |-> (!sys_rst && clk_rel));

    assert_wake_ignored_R10: assert property (@(posedge clk) disable iff (!arst_n)
        (st_q.ph != PH_RUN && !rst_req) |=> $stable(st_q.wake));

endmodule

// File: tb/sim_reset_release_seq.sv
module sim_reset_release_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P_POR  = 8;
    localparam int P_SU   = 5;
    localparam int P_PWRT = 40;
    localparam int P_RST  = 6;
    localparam int P_LOCK = 7;
    localparam int P_FSCM = 12;
    localparam int P_OST  = 16;
    localparam int OSC_DIV = 4;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       rst_req = 1'b0;
    logic [2:0] rst_cause = 3'd0;
    logic       wake_req = 1'b0;
    logic [2:0] clk_src = 3'd0;
    logic       reg_en = 1'b1;
    logic       osc_clk;
    logic       pll_locked = 1'b1;
    logic       sys_rst, clk_rel, mon_start;
    logic [6:0] phase;
    logic [1:0] osc_div = 2'd0;

    int total = 0;
    int bad = 0;

    reset_release_seq #(
        .T_POR(P_POR), .T_SU_REG(P_SU), .T_PWRT(P_PWRT), .T_RST(P_RST),
        .T_LOCK(P_LOCK), .T_FSCM(P_FSCM), .OST_COUNT(P_OST)
    ) u0 (
        .clk(clk), .arst_n(arst_n), .rst_req(rst_req), .rst_cause(rst_cause),
        .wake_req(wake_req), .clk_src(clk_src), .reg_en(reg_en), .osc_clk(osc_clk),
        .pll_locked(pll_locked), .sys_rst(sys_rst), .clk_rel(clk_rel),
        .mon_start(mon_start), .phase(phase)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) osc_div <= osc_div + 2'd1;
    assign osc_clk = osc_div[1];

    // Vector: [6:4] cause, [3:1] source class, [0] regulator enable
    localparam logic [6:0] VEC [12] = '{
        {3'd0, 3'd0, 1'b1}, {3'd0, 3'd0, 1'b0}, {3'd0, 3'd1, 1'b1}, {3'd0, 3'd2, 1'b1},
        {3'd0, 3'd3, 1'b0}, {3'd0, 3'd4, 1'b1}, {3'd2, 3'd2, 1'b1}, {3'd1, 3'd0, 1'b1},
        {3'd5, 3'd3, 1'b1}, {3'd6, 3'd4, 1'b0}, {3'd3, 3'd1, 1'b1}, {3'd4, 3'd2, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int oh2i(input logic [6:0] v);
        int r = 7;
        for (int i = 0; i < 7; i++) if (v == 7'(1 << i)) r = i;
        return r;
    endfunction

    function automatic string tag(input int p);
        case (p)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            4: return "R4";
            5: return "R7";
            default: return "R12";
        endcase
    endfunction

    // kind: 0 none (already running from block reset), 1 reset, 2 wake, 3 reset+wake together
    task automatic run_seq(input int kind, input logic [2:0] cause, input logic [2:0] src,
                           input logic regen, input int inj_wake);
        int exp_ph[16], exp_lo[16], exp_hi[16];
        int rec_ph[16], rec_len[16];
        int n_exp = 0, n_rec = 0, cyc = 0, mons = 0, out_bad = 0, idx;
        bit is_por, is_wake, xt, pl, fin = 0;
        is_wake = (kind == 2);
        is_por  = (kind == 0) || ((kind == 1 || kind == 3) && cause == 3'd0);
        xt = (src == 3'd2) || (src == 3'd3);
        pl = (src == 3'd1) || (src == 3'd3);
        if (is_por) begin
            exp_ph[n_exp] = 0; exp_lo[n_exp] = P_POR; exp_hi[n_exp] = P_POR; n_exp++;
            exp_ph[n_exp] = 1; exp_lo[n_exp] = regen ? P_SU : P_PWRT;
            exp_hi[n_exp] = exp_lo[n_exp]; n_exp++;
        end
        if (is_wake && regen) begin
            exp_ph[n_exp] = 1; exp_lo[n_exp] = P_SU; exp_hi[n_exp] = P_SU; n_exp++;
        end
        if ((is_por || is_wake) && xt) begin
            exp_ph[n_exp] = 2; exp_lo[n_exp] = (P_OST - 1) * OSC_DIV + 1;
            exp_hi[n_exp] = P_OST * OSC_DIV; n_exp++;
        end
        if ((is_por || is_wake) && pl) begin
            exp_ph[n_exp] = 3; exp_lo[n_exp] = P_LOCK; exp_hi[n_exp] = P_LOCK; n_exp++;
        end
        if (!is_wake) begin
            exp_ph[n_exp] = 4; exp_lo[n_exp] = P_RST; exp_hi[n_exp] = P_RST; n_exp++;
        end
        if (!is_wake && (xt || pl)) begin
            exp_ph[n_exp] = 5; exp_lo[n_exp] = P_FSCM; exp_hi[n_exp] = P_FSCM; n_exp++;
        end
        exp_ph[n_exp] = 6; exp_lo[n_exp] = 1; exp_hi[n_exp] = 1; n_exp++;

        clk_src = src;
        reg_en  = regen;
        if (kind != 0) begin
            rst_cause = cause;
            rst_req   = (kind == 1) || (kind == 3);
            wake_req  = (kind == 2) || (kind == 3);
            @(negedge clk);
            rst_req  = 1'b0;
            wake_req = 1'b0;
        end
        while (!fin && cyc < 3000) begin
            idx = oh2i(phase);
            wake_req = (cyc == inj_wake);
            if (sys_rst !== (!is_wake && idx <= 4)) out_bad++;
            if (clk_rel !== (idx >= 4 && idx <= 6)) out_bad++;
            if (mon_start) mons++;
            if (n_rec == 0 || rec_ph[n_rec-1] != idx) begin
                if (n_rec < 16) begin
                    rec_ph[n_rec] = idx; rec_len[n_rec] = 1; n_rec++;
                end
            end else begin
                rec_len[n_rec-1]++;
            end
            if (idx == 6) fin = 1;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
        wake_req = 1'b0;

        check(n_rec == n_exp, "R12 phase count", n_rec, n_exp);
        if (n_rec == n_exp) begin
            for (int i = 0; i < n_exp; i++) begin
                check(rec_ph[i] == exp_ph[i], "R12 phase order", rec_ph[i], exp_ph[i]);
                if (exp_ph[i] != 6)
                    check(rec_len[i] >= exp_lo[i] && rec_len[i] <= exp_hi[i],
                          tag(exp_ph[i]), rec_len[i], exp_lo[i]);
            end
        end
        check(out_bad == 0, is_wake ? "R9 outputs during wake" : "R8 reset/clock outputs",
              out_bad, 0);
        check(mons == ((!is_wake && (xt || pl)) ? 1 : 0), "R7 monitor pulses", mons,
              (!is_wake && (xt || pl)) ? 1 : 0);
    endtask

    task automatic wait_bit(input int b);
        for (int i = 0; i < 2000 && phase[b] !== 1'b1; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during block reset
        check(phase == 7'b0000001, "R1 phase in reset", int'(phase), 1);
        check(sys_rst == 1'b1, "R1 sys_rst in reset", int'(sys_rst), 1);
        check(clk_rel == 1'b0, "R1 clk_rel in reset", int'(clk_rel), 0);
        check(mon_start == 1'b0, "R1 mon_start in reset", int'(mon_start), 0);
        arst_n = 1'b1;
        run_seq(0, 3'd0, 3'd0, 1'b1, -1);

        // Table walk over causes and source classes (R2..R8)
        foreach (VEC[i]) run_seq(1, VEC[i][6:4], VEC[i][3:1], VEC[i][0], -1);

        // R9: wake sequences
        run_seq(2, 3'd0, 3'd2, 1'b1, -1);
        run_seq(2, 3'd0, 3'd3, 1'b0, -1);
        run_seq(2, 3'd0, 3'd0, 1'b0, -1);

        // R10: wake pulse mid-sequence is ignored
        run_seq(1, 3'd0, 3'd2, 1'b1, 3);
        run_seq(1, 3'd1, 3'd1, 1'b1, 2);

        // R11: reset and wake together -> reset wins
        run_seq(3, 3'd2, 3'd2, 1'b1, -1);

        // R11: restart from RST of a power-on sequence with a watchdog cause
        clk_src = 3'd2; reg_en = 1'b1; rst_cause = 3'd0; rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
        wait_bit(4);
        repeat (2) @(negedge clk);
        run_seq(1, 3'd2, 3'd2, 1'b1, -1);

        // R11: restart from OST with a new power-on request
        rst_cause = 3'd0; rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
        wait_bit(2);
        repeat (10) @(negedge clk);
        run_seq(1, 3'd0, 3'd2, 1'b1, -1);

        // R6: LOCK holds while the PLL is unlocked
        pll_locked = 1'b0; clk_src = 3'd1; reg_en = 1'b1; rst_cause = 3'd0; rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
        wait_bit(3);
        repeat (3 * P_LOCK) @(negedge clk);
        check(phase == 7'b0001000, "R6 held in LOCK while unlocked", int'(phase), 8);
        pll_locked = 1'b1;
        @(negedge clk);
        check(phase == 7'b0010000, "R6 leaves LOCK after lock", int'(phase), 16);
        wait_bit(6);
        check(phase == 7'b1000000, "R12 reaches RUN", int'(phase), 64);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule